// File: doc/BRIEF.md
# MDIO Management Master

This block lets a processor reach the management registers of an Ethernet PHY over the two-wire MDIO bus. Software writes a 32-bit command word that names a PHY address, a register index and a clock divider, and sets one of two start bits. The block then plays out a complete clause 22 frame on MDC and MDIO. The start bit it was given stays set until the frame ends, so it also serves as the busy flag that software polls.

A second 32-bit data word supplies the value for a write in its lower half. It returns the value of a read in its upper half. Software loads the write value first and then issues the command. The MDIO pad is split into an output, an output enable and an input. A line with no device answering is pulled high, so such a read returns all ones.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: After reset both register words read 0, MDC is low and the MDIO output enable is low.
- R2: Writing the command word (`reg_sel`=0) while idle stores the register index in bits 25:21, the PHY address in bits 20:16 and the divider in bits 7:0. Bit 26 set starts a read and bit 27 set starts a write. Reading back returns these fields, the active start bit and zeros elsewhere.
- R3: The start bit reads 1 from the cycle after the command write until the frame completes. The frame begins one cycle after the write and lasts 128×T cycles, where T is the divider (0 counts as 1). The bit then clears by itself.
- R4: MDC idles low. During a frame it runs 64 periods, each a low half of T cycles followed by a high half of T cycles.
- R5: A write frame drives, MSB first: 32 ones, 01, opcode 01, the 5-bit address, the 5-bit register, turnaround 10, then data-word bits 15:0. MDIO only changes while MDC falls or is low.
- R6: A read frame drives 32 ones, 01, opcode 10, address and register. It then releases MDIO (output enable low) for the two turnaround bits and the 16 data bits.
- R7: In a read, MDIO input is sampled at each rising MDC edge of the last 16 bits, MSB first. At completion the result appears in data-word bits 31:16, and bits 15:0 are unchanged.
- R8: A read from an address with no device, where the line stays high, returns 0xFFFF.
- R9: A command write while a frame runs is ignored: fields and busy bits are unchanged, and the running frame continues undisturbed.
- R10: If bits 26 and 27 are both set in one command write, the write wins: only bit 27 reads as set and a write frame is sent.
- R11: Writing the data word (`reg_sel`=1) updates only bits 15:0. Bits 31:16 change only when a read completes, and a write frame leaves them as they were.
- R12: A divider of 0 behaves exactly as a divider of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe, one cycle |
| reg_sel | input | 1 | 0 selects the command word, 1 the data word |
| reg_wdata | input | 32 | Register write value |
| cmd_rdata | output | 32 | Current command word with busy bits |
| data_rdata | output | 32 | Read result in 31:16, write value in 15:0 |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO value driven when enabled |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO value seen at the pad |

## Verification
The assertions assume that software never depends on a command write landing while the block is busy. They also assume that the MDIO input is only meaningful in the read data window, and that the divider fits the field width. The stimulus respects these assumptions. It deliberately issues one command write mid-frame and checks that the write is dropped. It also drives MDIO input from a behavioural PHY that answers only at its own address and otherwise leaves the line pulled high. Dividers of 0, 1, 2, 3 and 0x34 are used so that the half-period timing is exercised at its edges as well as at the normal setting.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;
  localparam int FRAME_BITS = 64;
  localparam int TA_POS     = 46;
  localparam int DATA_POS   = 48;

  typedef enum logic [1:0] {
    OP_WRITE = 2'b01,
    OP_READ  = 2'b10
  } mdio_op_e;

  localparam logic SEL_CMD  = 1'b0;
  localparam logic SEL_DATA = 1'b1;
endpackage

// File: rtl/mdio_mdc_tick.sv
module mdio_mdc_tick #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] limit,
  output logic             half_end
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] lim_eff;

  // a divider of zero is treated as one (R12)
  assign lim_eff  = (limit == '0) ? DIV_W'(1) : limit;
  assign half_end = run && (cnt_q == lim_eff - DIV_W'(1));

  always_ff @(posedge clk) begin
    if (rst || !run || half_end) cnt_q <= '0;
    else                         cnt_q <= cnt_q + DIV_W'(1);
  end

  a_r4_count_in_range: assert property (@(posedge clk) disable iff (rst)
    run |-> (cnt_q < lim_eff));
endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
  import mdio_mgmt_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic        is_write,
  input  logic [4:0]  phy_addr,
  input  logic [4:0]  reg_idx,
  input  logic [15:0] wr_value,
  input  logic        half_end,
  input  logic        mdio_i,
  output logic        active,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  output logic        done,
  output logic [15:0] rd_value
);
  localparam logic [5:0] LAST_BIT = 6'(FRAME_BITS - 1);
  localparam logic [5:0] TA_BIT   = 6'(TA_POS);
  localparam logic [5:0] DATA_BIT = 6'(DATA_POS);

  logic        active_q, mdc_q, mdio_o_q, mdio_oe_q, wr_q;
  logic [5:0]  bit_q;
  logic [63:0] shift_q;
  logic [15:0] cap_q;
  logic [63:0] frame_w;
  mdio_op_e    op_w;

  always_comb begin
    op_w    = is_write ? OP_WRITE : OP_READ;
    frame_w = {32'hFFFF_FFFF, 2'b01, op_w, phy_addr, reg_idx,
               (is_write ? 2'b10 : 2'b11),
               (is_write ? wr_value : 16'hFFFF)};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q  <= 1'b0;
      mdc_q     <= 1'b0;
      mdio_o_q  <= 1'b1;
      mdio_oe_q <= 1'b0;
      wr_q      <= 1'b0;
      bit_q     <= '0;
      shift_q   <= '0;
      cap_q     <= '0;
    end else if (!active_q) begin
      if (start) begin
        active_q  <= 1'b1;
        mdc_q     <= 1'b0;
        bit_q     <= '0;
        wr_q      <= is_write;
        shift_q   <= frame_w;
        mdio_o_q  <= frame_w[63];
        mdio_oe_q <= 1'b1;
      end
    end else if (half_end) begin
      if (!mdc_q) begin
        mdc_q <= 1'b1;
        if (!wr_q && bit_q >= DATA_BIT) cap_q <= {cap_q[14:0], mdio_i};
      end else begin
        mdc_q <= 1'b0;
        if (bit_q == LAST_BIT) begin
          active_q  <= 1'b0;
          mdio_oe_q <= 1'b0;
          mdio_o_q  <= 1'b1;
        end else begin
          bit_q     <= bit_q + 6'd1;
          shift_q   <= {shift_q[62:0], 1'b0};
          mdio_o_q  <= shift_q[62];
          mdio_oe_q <= wr_q || ((bit_q + 6'd1) < TA_BIT);
        end
      end
    end
  end

  assign active   = active_q;
  assign mdc      = mdc_q;
  assign mdio_o   = mdio_o_q;
  assign mdio_oe  = mdio_oe_q;
  assign rd_value = cap_q;
  assign done     = active_q && half_end && mdc_q && (bit_q == LAST_BIT);

  a_r4_idle_mdc_low: assert property (@(posedge clk) disable iff (rst)
    !active_q |-> !mdc_q);
  a_r5_hold_while_high: assert property (@(posedge clk) disable iff (rst)
    mdc_q |-> ($stable(mdio_o_q) && $stable(mdio_oe_q)));
  a_r6_release_on_read: assert property (@(posedge clk) disable iff (rst)
    (active_q && !wr_q && bit_q >= TA_BIT) |-> !mdio_oe_q);
endmodule

// File: rtl/mdio_csr.sv
module mdio_csr
  import mdio_mgmt_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [31:0]      wr_word,
  input  logic             done,
  input  logic [15:0]      rd_result,
  output logic             go_rd,
  output logic             go_wr,
  output logic [4:0]       phy_addr,
  output logic [4:0]       reg_idx,
  output logic [DIV_W-1:0] divider,
  output logic [15:0]      wr_value,
  output logic [31:0]      cmd_word,
  output logic [31:0]      data_word
);
  logic             go_rd_q, go_wr_q;
  logic [4:0]       phy_q, reg_q;
  logic [DIV_W-1:0] div_q;
  logic [15:0]      wlo_q, rhi_q;
  logic             busy;
  logic             unused_bits;

  assign busy        = go_rd_q || go_wr_q;
  assign unused_bits = ^wr_word[31:28];

  always_ff @(posedge clk) begin
    if (rst) begin
      go_rd_q <= 1'b0;
      go_wr_q <= 1'b0;
      phy_q   <= '0;
      reg_q   <= '0;
      div_q   <= '0;
      wlo_q   <= '0;
      rhi_q   <= '0;
    end else begin
      if (done) begin
        if (go_rd_q) rhi_q <= rd_result;
        go_rd_q <= 1'b0;
        go_wr_q <= 1'b0;
      end else if (wr_en && wr_sel == SEL_CMD && !busy) begin
        reg_q   <= wr_word[25:21];
        phy_q   <= wr_word[20:16];
        div_q   <= wr_word[DIV_W-1:0];
        go_wr_q <= wr_word[27];
        go_rd_q <= wr_word[26] && !wr_word[27];
      end
      if (wr_en && wr_sel == SEL_DATA) wlo_q <= wr_word[15:0];
    end
  end

  always_comb begin
    cmd_word              = '0;
    cmd_word[27]          = go_wr_q;
    cmd_word[26]          = go_rd_q;
    cmd_word[25:21]       = reg_q;
    cmd_word[20:16]       = phy_q;
    cmd_word[DIV_W-1:0]   = div_q;
  end

  assign data_word = {rhi_q, wlo_q};
  assign go_rd     = go_rd_q;
  assign go_wr     = go_wr_q;
  assign phy_addr  = phy_q;
  assign reg_idx   = reg_q;
  assign divider   = div_q;
  assign wr_value  = wlo_q;

  a_r10_one_start: assert property (@(posedge clk) disable iff (rst)
    $onehot0({go_wr_q, go_rd_q}));
  a_r9_fields_hold: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable({phy_q, reg_q, div_q}));
  a_r3_done_clears: assert property (@(posedge clk) disable iff (rst)
    done |=> !(go_rd_q || go_wr_q));
  a_r11_upper_on_read: assert property (@(posedge clk) disable iff (rst)
    !(done && go_rd_q) |=> $stable(rhi_q));
endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl #(
  parameter int DIV_W = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        reg_wr,
  input  logic        reg_sel,
  input  logic [31:0] reg_wdata,
  output logic [31:0] cmd_rdata,
  output logic [31:0] data_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  logic             go_rd, go_wr, active, done, half_end, start;
  logic [4:0]       phy_addr, reg_idx;
  logic [DIV_W-1:0] divider;
  logic [15:0]      wr_value, rd_value;

  assign start = (go_rd || go_wr) && !active;

  mdio_csr #(.DIV_W(DIV_W)) u_csr (
    .clk(clk), .rst(rst), .wr_en(reg_wr), .wr_sel(reg_sel), .wr_word(reg_wdata),
    .done(done), .rd_result(rd_value), .go_rd(go_rd), .go_wr(go_wr),
    .phy_addr(phy_addr), .reg_idx(reg_idx), .divider(divider),
    .wr_value(wr_value), .cmd_word(cmd_rdata), .data_word(data_rdata)
  );

  mdio_mdc_tick #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst(rst), .run(active), .limit(divider), .half_end(half_end)
  );

  mdio_frame_seq u_seq (
    .clk(clk), .rst(rst), .start(start), .is_write(go_wr),
    .phy_addr(phy_addr), .reg_idx(reg_idx), .wr_value(wr_value),
    .half_end(half_end), .mdio_i(mdio_i), .active(active), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .done(done), .rd_value(rd_value)
  );
endmodule

// File: tb/tb_mdio_mgmt_ctrl.sv
module tb_mdio_mgmt_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic        reg_sel = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] cmd_rdata, data_rdata;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  // reference model of the frame in flight
  bit          m_on = 0;
  int          m_a0 = 0;
  int          m_t = 1;
  bit          m_write = 0;
  logic [4:0]  m_phy = '0, m_reg = '0;
  logic [15:0] m_wlo = '0, m_rhi = '0;
  logic [15:0] phy_reg_val = 16'h0000;
  localparam logic [4:0] PHY_HERE = 5'd5;

  always #2 clk = ~clk;

  mdio_mgmt_ctrl dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .cmd_rdata(cmd_rdata), .data_rdata(data_rdata), .mdc(mdc), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  function automatic bit frame_bit(input int b);
    if (b < 32) return 1'b1;
    if (b == 32) return 1'b0;
    if (b == 33) return 1'b1;
    if (b == 34) return !m_write;
    if (b == 35) return m_write;
    if (b < 41) return m_phy[40 - b];
    if (b < 46) return m_reg[45 - b];
    if (b == 46) return 1'b1;
    if (b == 47) return 1'b0;
    return m_wlo[63 - b];
  endfunction

  // per-cycle comparison against the model, and the PHY side of the line
  always @(negedge clk) begin
    if (!rst) begin
      int k;
      int b;
      bit in_frame;
      logic e_mdc, e_oe;
      logic [1:0] e_busy;
      k = cyc - m_a0;
      in_frame = m_on && k >= 0 && k < 128 * m_t;
      b = in_frame ? k / (2 * m_t) : 0;
      e_mdc = in_frame && ((k % (2 * m_t)) >= m_t);
      e_oe  = in_frame && (m_write || b < 46);
      e_busy = (m_on && k >= -1 && k < 128 * m_t) ? (m_write ? 2'b10 : 2'b01) : 2'b00;
      chk(mdc === e_mdc, "R4 mdc", {31'b0, mdc}, {31'b0, e_mdc});
      chk(mdio_oe === e_oe, m_write ? "R5 oe" : "R6 oe", {31'b0, mdio_oe}, {31'b0, e_oe});
      if (e_oe)
        chk(mdio_o === frame_bit(b), m_write ? "R5 mdio" : "R6 mdio", {31'b0, mdio_o}, {31'b0, frame_bit(b)});
      chk(cmd_rdata[27:26] === e_busy, "R3 busy", {30'b0, cmd_rdata[27:26]}, {30'b0, e_busy});
      if (in_frame && !m_write && m_phy == PHY_HERE && b >= 48)
        mdio_i = phy_reg_val[63 - b];
      else
        mdio_i = 1'b1;
    end
  end

  task automatic launch(input logic [4:0] phy, input logic [4:0] rg, input logic [7:0] dv,
                        input bit rd_bit, input bit wr_bit);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = 1'b0;
    reg_wdata = {4'b0, wr_bit, rd_bit, rg, phy, 8'h00, dv};
    m_a0 = cyc + 2; m_t = (dv == 0) ? 1 : int'(dv);
    m_write = wr_bit; m_phy = phy; m_reg = rg; m_on = 1;
    @(negedge clk);
    reg_wr = 1'b0;
    chk(cmd_rdata === {4'b0, wr_bit, rd_bit && !wr_bit, rg, phy, 8'h00, dv}, "R2 cmd fields",
        cmd_rdata, {4'b0, wr_bit, rd_bit && !wr_bit, rg, phy, 8'h00, dv});
  endtask

  task automatic finish_frame();
    while (cyc < m_a0 + 128 * m_t + 1) @(negedge clk);
    if (!m_write) m_rhi = (m_phy == PHY_HERE) ? phy_reg_val : 16'hFFFF;
    chk(data_rdata === {m_rhi, m_wlo}, m_write ? "R11 data after write" : "R7 R8 read data",
        data_rdata, {m_rhi, m_wlo});
  endtask

  task automatic write_data(input logic [31:0] v);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = 1'b1; reg_wdata = v;
    @(negedge clk);
    reg_wr = 1'b0;
    m_wlo = v[15:0];
    chk(data_rdata === {m_rhi, m_wlo}, "R11 data write low half", data_rdata, {m_rhi, m_wlo});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(cmd_rdata === 32'h0, "R1 cmd reset", cmd_rdata, 32'h0);
    chk(data_rdata === 32'h0, "R1 data reset", data_rdata, 32'h0);
    chk(mdc === 1'b0 && mdio_oe === 1'b0, "R1 pins reset", {30'b0, mdc, mdio_oe}, 32'h0);

    write_data(32'hFFFF_A5C3);                 // R11 upper half untouched
    launch(5'd5, 5'h1B, 8'd3, 1'b0, 1'b1);     // R5 write frame
    finish_frame();

    phy_reg_val = 16'h1234;
    launch(5'd5, 5'h02, 8'd2, 1'b1, 1'b0);     // R6 R7 read frame
    repeat (40) @(negedge clk);
    @(negedge clk);                            // R9 write mid-frame
    reg_wr = 1'b1; reg_sel = 1'b0; reg_wdata = {4'b0, 1'b1, 1'b0, 5'h07, 5'h09, 8'h00, 8'h04};
    @(negedge clk);
    reg_wr = 1'b0;
    chk(cmd_rdata === {4'b0, 1'b0, 1'b1, 5'h02, 5'd5, 8'h00, 8'd2}, "R9 busy write ignored",
        cmd_rdata, {4'b0, 1'b0, 1'b1, 5'h02, 5'd5, 8'h00, 8'd2});
    finish_frame();

    launch(5'd17, 5'h03, 8'd1, 1'b1, 1'b0);    // R8 absent device
    finish_frame();
    chk(data_rdata[31:16] === 16'hFFFF, "R8 absent reads ones", {16'b0, data_rdata[31:16]}, 32'hFFFF);

    write_data(32'h0000_3C5A);
    launch(5'd5, 5'h11, 8'd0, 1'b1, 1'b1);     // R10 both bits, R12 divider zero
    finish_frame();
    chk(data_rdata[31:16] === 16'hFFFF, "R11 upper kept after write", {16'b0, data_rdata[31:16]}, 32'hFFFF);

    phy_reg_val = 16'hBEEF;
    launch(5'd5, 5'h01, 8'h34, 1'b1, 1'b0);    // R4 normal divider
    finish_frame();
    repeat (4) @(negedge clk);
    chk(cmd_rdata[27:26] === 2'b00, "R3 self clear", {30'b0, cmd_rdata[27:26]}, 32'h0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule